// File: doc/BRIEF.md
# Operand-Wakeup Instruction Window

This block is a small central instruction window for an out-of-order core. The decode stage places decoded instructions into it. Each instruction carries an opcode tag, up to two source register names and one target register name. The instructions wait in the window until their operands are known to be available. The window then sends ready instructions, one per cycle, to functional units that sit outside the block. Those units report completion back by giving the index of the window entry. The window then retires entries strictly in the order they were dispatched. Data values never enter the block; it tracks register names and entry states only.

When a completion is reported, the window broadcasts the target register name of the completing entry. Every waiting entry compares that name with its sources and marks each matching source as available. An entry moves through the states waiting, ready, executing and completed, and is freed when it commits. A squash input throws away every uncommitted entry, so that an interrupt sees only committed results.

Top module: `rsv_window`

## Requirements
- R1: After reset the window is empty: `disp_ready` is 1, and `iss_valid` and `cmt_valid` are 0.
- R2: Entries are allocated in consecutive indices that wrap modulo 8, starting at index 0 after reset. A source is available at dispatch if its `used` bit is 0 or its `rdy` bit is 1. An unused source never waits, even when its name matches a pending register. An entry whose two sources are available is offered on `iss_valid`/`iss_idx`/`iss_op`/`iss_tgt` in the cycle after its dispatch edge, and it is marked executing at that edge.
- R3: A completion (`cmp_valid` with `cmp_idx`) broadcasts that entry's target name. Every waiting source with the same name becomes available. A waiting entry whose last operand is woken is offered for issue in the cycle after the completion edge.
- R4: A broadcast in the same cycle as the dispatch of an entry also wakes the matching sources of the entry being dispatched.
- R5: When several entries are ready, the oldest in dispatch order is issued. At most one entry is issued per cycle.
- R6: Completion may occur in any order. Commit is strictly in dispatch order: `cmt_valid` is 1, showing the head entry's op and target, in the cycle after the head entry has completed. Exactly one entry is freed per commit.
- R7: When 8 entries are occupied, `disp_ready` is 0 and a dispatch attempt is ignored (no entry is created or issued from it).
- R8: `squash` discards every uncommitted entry, including completed ones. No discarded entry is issued or committed afterwards, and the next dispatch is allocated at the index of the oldest discarded entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | 4 | Opcode tag |
| disp_src1 | input | 5 | First source register name |
| disp_src1_used | input | 1 | First source is read |
| disp_src1_rdy | input | 1 | First source available at dispatch |
| disp_src2 | input | 5 | Second source register name |
| disp_src2_used | input | 1 | Second source is read |
| disp_src2_rdy | input | 1 | Second source available at dispatch |
| disp_tgt | input | 5 | Target register name |
| disp_ready | output | 1 | A free entry exists |
| iss_valid | output | 1 | An entry starts execution this cycle |
| iss_idx | output | 3 | Index of the issuing entry |
| iss_op | output | 4 | Opcode tag of the issuing entry |
| iss_tgt | output | 5 | Target of the issuing entry |
| cmp_valid | input | 1 | A functional unit finished an entry |
| cmp_idx | input | 3 | Index of the finished entry |
| cmt_valid | output | 1 | Head entry commits this cycle |
| cmt_op | output | 4 | Opcode tag of the committing entry |
| cmt_tgt | output | 5 | Target of the committing entry |
| squash | input | 1 | Discard all uncommitted entries |

## Verification
The bench targets these cases:
- A consumer dispatched in the same cycle as its producer's completion. A design that ignored this would leave the consumer waiting forever.
- Two entries woken by one broadcast. Issuing the younger one first would break age order.
- A younger entry that completes before an older one. A design that committed on completion instead of at the head would retire it early.
- A window that is full. A dispatch accepted while full would overwrite the head.
- A squash with a completed but uncommitted entry present. A design that kept that entry would later commit a discarded result, or allocate at the wrong index.

// File: rtl/rsv_window.sv
module rsv_window #(
  parameter int DEPTH = 8,
  parameter int REG_W = 5,
  parameter int OP_W  = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [OP_W-1:0]  disp_op,
  input  logic [REG_W-1:0] disp_src1,
  input  logic             disp_src1_used,
  input  logic             disp_src1_rdy,
  input  logic [REG_W-1:0] disp_src2,
  input  logic             disp_src2_used,
  input  logic             disp_src2_rdy,
  input  logic [REG_W-1:0] disp_tgt,
  output logic             disp_ready,
  output logic             iss_valid,
  output logic [IW-1:0]    iss_idx,
  output logic [OP_W-1:0]  iss_op,
  output logic [REG_W-1:0] iss_tgt,
  input  logic             cmp_valid,
  input  logic [IW-1:0]    cmp_idx,
  output logic             cmt_valid,
  output logic [OP_W-1:0]  cmt_op,
  output logic [REG_W-1:0] cmt_tgt,
  input  logic             squash
);
  typedef enum logic [2:0] {ST_FREE, ST_WAIT, ST_RDY, ST_EXEC, ST_DONE} st_t;

  st_t              st   [DEPTH];
  logic [OP_W-1:0]  op   [DEPTH];
  logic [REG_W-1:0] s1   [DEPTH];
  logic [REG_W-1:0] s2   [DEPTH];
  logic [REG_W-1:0] tgt  [DEPTH];
  logic             a1   [DEPTH];
  logic             a2   [DEPTH];
  logic [IW-1:0]    head, tail;
  logic [IW:0]      cnt;
  logic             sel_found;
  logic [IW-1:0]    sel_idx;

  wire              bc_v   = cmp_valid && !squash;
  wire [REG_W-1:0]  bc_reg = tgt[cmp_idx];
  wire              accept = disp_valid && disp_ready && !squash;
  wire              n1 = !disp_src1_used || disp_src1_rdy || (bc_v && disp_src1 == bc_reg);
  wire              n2 = !disp_src2_used || disp_src2_rdy || (bc_v && disp_src2 == bc_reg);

  assign disp_ready = cnt != (IW+1)'(DEPTH);
  assign iss_valid  = sel_found && !squash;
  assign iss_idx    = sel_idx;
  assign iss_op     = op[sel_idx];
  assign iss_tgt    = tgt[sel_idx];
  assign cmt_valid  = !squash && st[head] == ST_DONE;
  assign cmt_op     = op[head];
  assign cmt_tgt    = tgt[head];

  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!sel_found && st[head + IW'(k)] == ST_RDY) begin
        sel_found = 1'b1;
        sel_idx   = head + IW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || squash) begin
      if (!rst_n) head <= '0;
      tail <= rst_n ? head : '0;
      cnt  <= '0;
    end else begin
      if (accept) tail <= tail + 1'b1;
      if (cmt_valid) head <= head + 1'b1;
      cnt <= cnt + (IW+1)'(accept) - (IW+1)'(cmt_valid);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n || squash) begin
        st[i] <= ST_FREE;
      end else if (accept && tail == IW'(i)) begin
        st[i]  <= (n1 && n2) ? ST_RDY : ST_WAIT;
        a1[i]  <= n1;
        a2[i]  <= n2;
        op[i]  <= disp_op;
        s1[i]  <= disp_src1;
        s2[i]  <= disp_src2;
        tgt[i] <= disp_tgt;
      end else begin
        case (st[i])
          ST_WAIT: begin
            a1[i] <= a1[i] || (bc_v && s1[i] == bc_reg);
            a2[i] <= a2[i] || (bc_v && s2[i] == bc_reg);
            if ((a1[i] || (bc_v && s1[i] == bc_reg)) && (a2[i] || (bc_v && s2[i] == bc_reg)))
              st[i] <= ST_RDY;
          end
          ST_RDY:  if (iss_valid && sel_idx == IW'(i)) st[i] <= ST_EXEC;
          ST_EXEC: if (bc_v && cmp_idx == IW'(i)) st[i] <= ST_DONE;
          ST_DONE: if (cmt_valid && head == IW'(i)) st[i] <= ST_FREE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rsv_window_chk.sv
module rsv_window_chk #(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic          iss_valid,
  input logic [IW-1:0] iss_idx,
  input logic          cmt_valid,
  input logic          squash
);
  localparam int OW = $clog2(DEPTH + 1);
  logic [OW-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n || squash) occ <= '0;
    else occ <= occ + OW'(disp_valid && disp_ready) - OW'(cmt_valid);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !iss_valid && !cmt_valid);
  assert_issue_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !(iss_valid && iss_idx == $past(iss_idx)));
  assert_commit_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> occ != '0);
  assert_issue_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> occ != '0);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ready == (occ != OW'(DEPTH)));
  assert_squash_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !cmt_valid && !iss_valid);
endmodule

bind rsv_window rsv_window_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .iss_valid(iss_valid), .iss_idx(iss_idx), .cmt_valid(cmt_valid), .squash(squash));

// File: tb/test_rsv_window.sv
`timescale 1ns/1ps
module test_rsv_window;
  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, s1u = 0, s1r = 0, s2u = 0, s2r = 0, cmp_valid = 0, squash = 0;
  logic [3:0] disp_op = 0;
  logic [4:0] disp_src1 = 0, disp_src2 = 0, disp_tgt = 0;
  logic [2:0] cmp_idx = 0;
  logic disp_ready, iss_valid, cmt_valid;
  logic [2:0] iss_idx;
  logic [3:0] iss_op, cmt_op;
  logic [4:0] iss_tgt, cmt_tgt;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  rsv_window i_rsv_window (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_src1(disp_src1), .disp_src1_used(s1u), .disp_src1_rdy(s1r),
    .disp_src2(disp_src2), .disp_src2_used(s2u), .disp_src2_rdy(s2r),
    .disp_tgt(disp_tgt), .disp_ready(disp_ready), .iss_valid(iss_valid),
    .iss_idx(iss_idx), .iss_op(iss_op), .iss_tgt(iss_tgt), .cmp_valid(cmp_valid),
    .cmp_idx(cmp_idx), .cmt_valid(cmt_valid), .cmt_op(cmt_op), .cmt_tgt(cmt_tgt),
    .squash(squash));

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic disp(int op, int a, bit au, bit ar, int b, bit bu, bit br, int t);
    disp_valid = 1; disp_op = 4'(op); disp_src1 = 5'(a); s1u = au; s1r = ar;
    disp_src2 = 5'(b); s2u = bu; s2r = br; disp_tgt = 5'(t);
  endtask

  task automatic nodisp();
    disp_valid = 0; s1u = 0; s1r = 0; s2u = 0; s2r = 0;
  endtask

  task automatic done(int idx);
    cmp_valid = 1; cmp_idx = 3'(idx);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 disp_ready", disp_ready, 1);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 cmt_valid", cmt_valid, 0);
  endtask

  task automatic t_basic();
    tick(); disp(1, 20, 0, 0, 21, 0, 0, 3);
    tick(); nodisp(); #1;
    chk("R2 unused srcs issue", iss_valid, 1);
    chk("R2 first idx 0", iss_idx, 0);
    chk("R2 iss_op", iss_op, 1);
    chk("R2 iss_tgt", iss_tgt, 3);
    tick(); chk("R2 issued once", iss_valid, 0);
    chk("R6 no commit before done", cmt_valid, 0);
    done(0);
    tick(); cmp_valid = 0; #1;
    chk("R6 commit valid", cmt_valid, 1);
    chk("R6 commit op", cmt_op, 1);
    chk("R6 commit tgt", cmt_tgt, 3);
    tick(); chk("R6 freed", cmt_valid, 0);
  endtask

  task automatic t_wake();
    tick(); disp(2, 0, 0, 0, 0, 0, 0, 5);
    tick(); disp(3, 5, 1, 0, 0, 0, 0, 6); #1;
    chk("R3 producer issues", iss_idx, 1);
    tick(); nodisp(); #1;
    chk("R3 consumer waits", iss_valid, 0);
    done(1); #1;
    chk("R3 no early wake", iss_valid, 0);
    tick(); cmp_valid = 0; #1;
    chk("R3 woken issue", iss_valid, 1);
    chk("R3 woken idx", iss_idx, 2);
    chk("R3 woken op", iss_op, 3);
    chk("R6 producer commits", cmt_op, 2);
    tick(); chk("R3 idle", iss_valid, 0);
    done(2);
    tick(); cmp_valid = 0; #1;
    chk("R6 consumer commits", cmt_op, 3);
    tick();
  endtask

  task automatic t_same();
    disp(4, 0, 0, 0, 0, 0, 0, 7);
    tick(); nodisp(); #1;
    chk("R4 producer issues", iss_idx, 3);
    tick(); done(3); disp(5, 7, 1, 0, 8, 1, 1, 9);
    tick(); cmp_valid = 0; nodisp(); #1;
    chk("R4 same-cycle wake", iss_valid, 1);
    chk("R4 same-cycle idx", iss_idx, 4);
    chk("R6 commit producer", cmt_op, 4);
    tick(); done(4);
    tick(); cmp_valid = 0; #1;
    chk("R6 commit consumer", cmt_op, 5);
    tick();
  endtask

  task automatic t_order();
    disp(6, 0, 0, 0, 0, 0, 0, 10);
    tick(); disp(7, 10, 1, 0, 0, 0, 0, 11); #1;
    chk("R5 producer idx", iss_idx, 5);
    tick(); disp(8, 0, 0, 0, 10, 1, 0, 12); #1;
    chk("R5 waiting", iss_valid, 0);
    tick(); nodisp(); done(5); #1;
    chk("R5 still waiting", iss_valid, 0);
    tick(); cmp_valid = 0; #1;
    chk("R5 oldest first", iss_idx, 6);
    chk("R5 oldest valid", iss_valid, 1);
    tick(); chk("R5 younger next", iss_idx, 7);
    chk("R5 younger valid", iss_valid, 1);
    tick(); chk("R5 none left", iss_valid, 0);
    done(7);
    tick(); cmp_valid = 0; #1;
    chk("R6 younger done waits", cmt_valid, 0);
    done(6);
    tick(); cmp_valid = 0; #1;
    chk("R6 older commits", cmt_op, 7);
    tick(); chk("R6 younger commits", cmt_op, 8);
    chk("R6 younger valid", cmt_valid, 1);
    tick(); chk("R6 drained", cmt_valid, 0);
  endtask

  task automatic t_full();
    for (int k = 0; k < 8; k++) begin
      disp(k, 20, 1, 0, 0, 0, 0, 1);
      tick();
    end
    nodisp(); #1;
    chk("R7 full", disp_ready, 0);
    disp(15, 0, 0, 0, 0, 0, 0, 2);
    tick(); nodisp(); #1;
    chk("R7 ignored dispatch", iss_valid, 0);
    squash = 1;
    tick(); squash = 0; #1;
    chk("R8 room after squash", disp_ready, 1);
    chk("R8 nothing issues", iss_valid, 0);
    chk("R8 nothing commits", cmt_valid, 0);
  endtask

  task automatic t_squash_done();
    disp(9, 22, 1, 0, 0, 0, 0, 13);
    tick(); disp(10, 0, 0, 0, 0, 0, 0, 11);
    tick(); nodisp(); #1;
    chk("R8 younger issues", iss_idx, 1);
    tick(); done(1);
    tick(); cmp_valid = 0; #1;
    chk("R6 blocked by head", cmt_valid, 0);
    squash = 1;
    tick(); squash = 0; #1;
    chk("R8 done entry dropped", cmt_valid, 0);
    disp(6, 0, 0, 0, 0, 0, 0, 12);
    tick(); nodisp(); #1;
    chk("R8 realloc idx", iss_idx, 0);
    chk("R8 realloc op", iss_op, 6);
    tick(); done(0);
    tick(); cmp_valid = 0; #1;
    chk("R8 new entry commits", cmt_op, 6);
    chk("R8 new entry tgt", cmt_tgt, 12);
    tick(); chk("R8 stale not committed", cmt_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_wake();
    t_same();
    t_order();
    t_full();
    t_squash_done();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule